// File: doc/BRIEF.md
# Page-Mode Asynchronous Memory Read Sequencer

This block turns burst read requests from an internal bus into strobe sequences for an external asynchronous memory that has a page mode. A request carries a start address, a beat count and the memory data width (8, 16 or 32 bits). The block drives the memory address, an active-low chip select and an active-low read strobe. It samples the returned word at the end of every access and hands each word back with a one-cycle valid strobe.

Four configuration inputs set the timing: a page-mode enable, the page size, the pulse length of a first access into a page, and the shorter pulse length of a later access inside the same page. These values are taken when a request is accepted. In page mode the strobes stay low for the whole burst. When a beat moves into a new page, the next beat simply pays the longer first-access time again. With page mode off, each beat is a separate single access of the first-access length, and the strobes go high between beats.

Top module: `pgmem_reader`

## Requirements
- R1: After reset, mem_ncs_n and mem_nrd_n are high, req_ready is high, and rd_valid and done are low.
- R2: A request is accepted at a clock edge where req_valid and req_ready are both high. Its first access starts in the next cycle. The configuration inputs are sampled at that same edge. req_valid while busy, and configuration changes during a burst, have no effect on the burst.
- R3: req_width 0 selects 8-bit beats (step 1). Value 1 selects 16-bit beats (step 2, address bit 0 driven 0). Values 2 and 3 select 32-bit beats (step 4, address bits 1:0 driven 0). Beat k is driven at the aligned start address plus k times the step, and the address is stable within an access.
- R4: cfg_page_size 0, 1, 2 and 3 select pages of 4, 8, 16 and 32 bytes. Two beats share a page when their address bits above log2(page bytes) are equal.
- R5: The first beat of a burst lasts cfg_first_len cycles. In page mode, a beat in the same page as the previous beat lasts cfg_next_len cycles, and a beat in a new page lasts cfg_first_len cycles. A length of 0 counts as 1.
- R6: In page mode, mem_ncs_n and mem_nrd_n stay low without a break from the first access cycle to the last, across page crossings.
- R7: With page mode off, every beat lasts cfg_first_len cycles, and both strobes go high for exactly one cycle between beats.
- R8: rd_valid is high for one cycle right after the last cycle of each access. rd_data then holds the value that mem_rdata had in that last cycle.
- R9: In the cycle after the final access, both strobes are high, and done and req_ready are high together with the final rd_valid. A new request can be accepted in that cycle.
- R10: A beat count of 0 is treated as 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_page_en | input | 1 | Page mode enable |
| cfg_page_size | input | 2 | Page size select: 4, 8, 16 or 32 bytes |
| cfg_first_len | input | 6 | First-access pulse length in cycles |
| cfg_next_len | input | 6 | In-page access pulse length in cycles |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Sequencer idle, request may be taken |
| req_addr | input | ADDR_W | Burst start byte address |
| req_beats | input | BEAT_W | Number of beats (0 means 1) |
| req_width | input | 2 | Memory data width code |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ncs_n | output | 1 | Chip select, active low |
| mem_nrd_n | output | 1 | Read strobe, active low |
| mem_rdata | input | DATA_W | Data returned by the memory |
| rd_valid | output | 1 | One-cycle strobe for a captured beat |
| rd_data | output | DATA_W | Captured beat |
| done | output | 1 | One-cycle pulse when the burst ends |

## Verification
The cycle that ends a burst carries three events at once: the final beat's data strobe, the done pulse, and a free sequencer that can accept the next request. The bench provokes this by presenting a second request in exactly the cycle where done is expected, so the new burst starts one cycle later with its freshly sampled configuration. A behavioural model builds the expected per-cycle trace of both bursts from the requirements. Every clock, the bench compares strobes, address, valid, data, done and ready against that trace, so a lost beat, a late start or a stale configuration shows up as a mismatch.

// File: rtl/pgrd_pkg.sv
package pgrd_pkg;

    localparam int LEN_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_GAP    = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic             page_en;
        logic [1:0]       page_sel;
        logic [LEN_W-1:0] first_len;
        logic [LEN_W-1:0] next_len;
    } rd_cfg_t;

    // byte step per beat for a width code
    function automatic logic [2:0] step_of(input logic [1:0] w);
        case (w)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // zero-length pulses behave as one cycle
    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] v);
        return (v == '0) ? LEN_W'(1) : v;
    endfunction

endpackage

// File: rtl/pgrd_pulse_timer.sv
module pgrd_pulse_timer
    import pgrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len_in,
    output logic             last
);

    logic [LEN_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= LEN_W'(1);
        end else if (load) begin
            cnt <= clamp_len(len_in);
        end else if (cnt > LEN_W'(1)) begin
            cnt <= cnt - LEN_W'(1);
        end
    end

    assign last = (cnt == LEN_W'(1));

endmodule

// File: rtl/pgrd_addr_gen.sv
module pgrd_addr_gen
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              advance,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        width_in,
    input  logic [1:0]        page_sel,
    output logic [ADDR_W-1:0] addr_o,
    output logic              next_same_page
);

    logic [1:0]        width_q;
    logic [ADDR_W-1:0] cur;
    logic [ADDR_W-1:0] nxt;
    logic [ADDR_W-1:0] start_aligned;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        start_aligned = start_addr & ~(ADDR_W'(step_of(width_in)) - ADDR_W'(1));
        nxt           = cur + ADDR_W'(step_of(width_q));
        diff          = cur ^ nxt;
        next_same_page = ((diff >> (32'(page_sel) + 32'd2)) == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur     <= '0;
            width_q <= 2'd0;
        end else if (start) begin
            cur     <= start_aligned;
            width_q <= width_in;
        end else if (advance) begin
            cur     <= nxt;
        end
    end

    assign addr_o = cur;

endmodule

// File: rtl/pgrd_seq_ctrl.sv
module pgrd_seq_ctrl
    import pgrd_pkg::*;
#(
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [BEAT_W-1:0] req_beats,
    input  rd_cfg_t           cfg_in,
    input  logic              pulse_last,
    input  logic              same_page,
    output logic              req_ready,
    output logic              acc_active,
    output logic              tmr_load,
    output logic [LEN_W-1:0]  tmr_len,
    output logic              addr_start,
    output logic              addr_adv,
    output logic [1:0]        page_sel,
    output logic              beat_end,
    output logic              burst_end
);

    rd_state_e         state;
    rd_cfg_t           cfg_q;
    logic [BEAT_W-1:0] beats_left;
    logic              accept;
    logic              last_beat;

    always_comb begin
        req_ready  = (state == ST_IDLE);
        accept     = req_ready && req_valid;
        acc_active = (state == ST_ACCESS);
        beat_end   = acc_active && pulse_last;
        last_beat  = (beats_left == BEAT_W'(1));
        addr_start = accept;
        addr_adv   = beat_end && !last_beat;
        burst_end  = beat_end && last_beat;
        tmr_load   = accept || (state == ST_GAP) || (addr_adv && cfg_q.page_en);
        if (accept)
            tmr_len = cfg_in.first_len;
        else if (state == ST_GAP)
            tmr_len = cfg_q.first_len;
        else if (same_page)
            tmr_len = cfg_q.next_len;
        else
            tmr_len = cfg_q.first_len;
        page_sel   = cfg_q.page_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cfg_q      <= '0;
            beats_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cfg_q      <= cfg_in;
                        beats_left <= (req_beats == '0) ? BEAT_W'(1) : req_beats;
                        state      <= ST_ACCESS;
                    end
                end
                ST_ACCESS: begin
                    if (pulse_last) begin
                        if (last_beat) begin
                            state <= ST_IDLE;
                        end else begin
                            beats_left <= beats_left - BEAT_W'(1);
                            state      <= cfg_q.page_en ? ST_ACCESS : ST_GAP;
                        end
                    end
                end
                ST_GAP:  state <= ST_ACCESS;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pgmem_reader.sv
module pgmem_reader
    import pgrd_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int DATA_W = 32,
    parameter int BEAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_page_en,
    input  logic [1:0]        cfg_page_size,
    input  logic [LEN_W-1:0]  cfg_first_len,
    input  logic [LEN_W-1:0]  cfg_next_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BEAT_W-1:0] req_beats,
    input  logic [1:0]        req_width,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ncs_n,
    output logic              mem_nrd_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    rd_cfg_t          cfg_in;
    logic             pulse_last;
    logic             same_page;
    logic             acc_active;
    logic             tmr_load;
    logic [LEN_W-1:0] tmr_len;
    logic             addr_start;
    logic             addr_adv;
    logic [1:0]       page_sel;
    logic             beat_end;
    logic             burst_end;

    always_comb begin
        cfg_in.page_en   = cfg_page_en;
        cfg_in.page_sel  = cfg_page_size;
        cfg_in.first_len = cfg_first_len;
        cfg_in.next_len  = cfg_next_len;
    end

    pgrd_seq_ctrl #(.BEAT_W(BEAT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_beats  (req_beats),
        .cfg_in     (cfg_in),
        .pulse_last (pulse_last),
        .same_page  (same_page),
        .req_ready  (req_ready),
        .acc_active (acc_active),
        .tmr_load   (tmr_load),
        .tmr_len    (tmr_len),
        .addr_start (addr_start),
        .addr_adv   (addr_adv),
        .page_sel   (page_sel),
        .beat_end   (beat_end),
        .burst_end  (burst_end)
    );

    pgrd_pulse_timer u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .len_in (tmr_len),
        .last   (pulse_last)
    );

    pgrd_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk            (clk),
        .rst            (rst),
        .start          (addr_start),
        .advance        (addr_adv),
        .start_addr     (req_addr),
        .width_in       (req_width),
        .page_sel       (page_sel),
        .addr_o         (mem_addr),
        .next_same_page (same_page)
    );

    assign mem_ncs_n = ~acc_active;
    assign mem_nrd_n = ~acc_active;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= beat_end;
            done     <= burst_end;
            if (beat_end)
                rd_data <= mem_rdata;
        end
    end

endmodule

// File: rtl/pgmem_reader_chk.sv
module pgmem_reader_chk #(
    parameter int ADDR_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ncs_n,
    input logic              mem_nrd_n,
    input logic              rd_valid,
    input logic              done
);

    // R1: an idle sequencer keeps the memory deselected
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ncs_n && mem_nrd_n));

    // R2: an accepted request drives an access in the following cycle
    p_accept_starts_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (!mem_ncs_n && !mem_nrd_n));

    // R3: address holds while an access is in progress
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!mem_ncs_n && $past(!mem_ncs_n) && !rd_valid) |-> $stable(mem_addr));

    // R8: each data strobe follows a cycle with the memory selected
    p_valid_after_access_r8: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(!mem_ncs_n));

    // R9: done comes with the final beat's strobe
    p_done_with_valid_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_valid);

    // R9: done marks a free sequencer
    p_done_ready_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (req_ready && mem_ncs_n));

endmodule

bind pgmem_reader pgmem_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ncs_n (mem_ncs_n),
    .mem_nrd_n (mem_nrd_n),
    .rd_valid  (rd_valid),
    .done      (done)
);

// File: tb/pgmem_reader_test.sv
module pgmem_reader_test;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic        ncs;
        logic        chk_addr;
        logic [25:0] addr;
        logic        rv;
        logic [31:0] data;
        logic        done;
        logic        ready;
    } cyc_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_page_en = 1'b0;
    logic [1:0]  cfg_page_size = 2'd0;
    logic [5:0]  cfg_first_len = 6'd1;
    logic [5:0]  cfg_next_len = 6'd1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [25:0] req_addr = '0;
    logic [7:0]  req_beats = 8'd1;
    logic [1:0]  req_width = 2'd0;
    logic [25:0] mem_addr;
    logic        mem_ncs_n;
    logic        mem_nrd_n;
    logic [31:0] mem_rdata;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        done;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cur_ready = 1'b1;
    string cur_test = "reset";
    cyc_t  exp_q[$];

    function automatic logic [31:0] mem_word(input logic [25:0] a);
        return {a[15:0], ~a[15:0]} ^ 32'h3C5A_0F96;
    endfunction

    assign mem_rdata = mem_word(mem_addr);

    always #(CLK_PERIOD/2) clk = ~clk;

    pgmem_reader uut (
        .clk (clk), .rst (rst),
        .cfg_page_en (cfg_page_en), .cfg_page_size (cfg_page_size),
        .cfg_first_len (cfg_first_len), .cfg_next_len (cfg_next_len),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .req_beats (req_beats), .req_width (req_width),
        .mem_addr (mem_addr), .mem_ncs_n (mem_ncs_n), .mem_nrd_n (mem_nrd_n),
        .mem_rdata (mem_rdata), .rd_valid (rd_valid), .rd_data (rd_data),
        .done (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", tag, cur_test, $time, act, expv);
        end
    endtask

    task automatic compare();
        cyc_t e;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
        end else begin
            e.ncs = 1'b1; e.chk_addr = 1'b0; e.addr = '0; e.rv = 1'b0;
            e.data = '0; e.done = 1'b0; e.ready = 1'b1;
        end
        chk(mem_ncs_n === e.ncs, "R6 chip select", 32'(mem_ncs_n), 32'(e.ncs));
        chk(mem_nrd_n === e.ncs, "R6 read strobe", 32'(mem_nrd_n), 32'(e.ncs));
        if (e.chk_addr)
            chk(mem_addr === e.addr, "R3 address", 32'(mem_addr), 32'(e.addr));
        chk(rd_valid === e.rv, "R8 valid", 32'(rd_valid), 32'(e.rv));
        if (e.rv)
            chk(rd_data === e.data, "R8 data", rd_data, e.data);
        chk(done === e.done, "R9 done", 32'(done), 32'(e.done));
        chk(req_ready === e.ready, "R2 ready", 32'(req_ready), 32'(e.ready));
        cur_ready = e.ready;
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic push(input logic ncs, input logic [25:0] a, input logic rv,
                        input logic [31:0] d, input logic dn, input logic rdy);
        cyc_t c;
        c.ncs = ncs; c.chk_addr = 1'b1; c.addr = a; c.rv = rv;
        c.data = d; c.done = dn; c.ready = rdy;
        exp_q.push_back(c);
    endtask

    // behavioural expected trace of one burst, from the requirements
    task automatic model_burst(input logic [25:0] addr, input int beats, input int w,
                               input bit pg, input int sel, input int first, input int nxt);
        int n, st, len, fl, nl;
        logic [25:0] base, a, prev;
        n  = (beats == 0) ? 1 : beats;
        st = (w == 0) ? 1 : (w == 1) ? 2 : 4;
        fl = (first == 0) ? 1 : first;
        nl = (nxt == 0) ? 1 : nxt;
        base = addr & ~26'(st - 1);
        prev = base;
        for (int b = 0; b < n; b++) begin
            a = base + 26'(b * st);
            if (b == 0 || !pg || ((prev >> (sel + 2)) != (a >> (sel + 2))))
                len = fl;
            else
                len = nl;
            if (b > 0 && !pg)
                push(1'b1, a, 1'b1, mem_word(prev), 1'b0, 1'b0);
            for (int i = 0; i < len; i++)
                push(1'b0, a, (i == 0 && b > 0 && pg), mem_word(prev), 1'b0, 1'b0);
            prev = a;
        end
        push(1'b1, prev, 1'b1, mem_word(prev), 1'b1, 1'b1);
    endtask

    task automatic issue(input string name, input logic [25:0] addr, input int beats,
                         input int w, input bit pg, input int sel, input int first, input int nxt);
        while (!cur_ready) step();
        cur_test      = name;
        cfg_page_en   = pg;
        cfg_page_size = 2'(sel);
        cfg_first_len = 6'(first);
        cfg_next_len  = 6'(nxt);
        req_addr      = addr;
        req_beats     = 8'(beats);
        req_width     = 2'(w);
        req_valid     = 1'b1;
        model_burst(addr, beats, w, pg, sel, first, nxt);
        step();
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) step();
        step();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_test = "R1 reset state";
        step();
        step();

        // R5 R6: same-page beats use the short pulse, strobes held low
        issue("R5 R6 in-page 32-bit", 26'h000100, 4, 2, 1'b1, 2, 5, 2);
        drain();
        // R4 R5: page crossings with 8-byte pages reload the first-access length
        issue("R4 R5 crossing 8B", 26'h000204, 4, 2, 1'b1, 1, 4, 1);
        drain();
        // R3 R4: byte beats, 4-byte pages
        issue("R3 R4 byte beats", 26'h000003, 6, 0, 1'b1, 0, 3, 2);
        drain();
        // R3: 16-bit beats from an odd start address
        issue("R3 16-bit align", 26'h000011, 5, 1, 1'b1, 2, 3, 1);
        drain();
        // R7: page mode off gives gaps and full-length beats
        issue("R7 single accesses", 26'h000040, 3, 2, 1'b0, 3, 3, 1);
        drain();
        // R5: zero lengths behave as one cycle
        issue("R5 zero lengths", 26'h000080, 4, 2, 1'b1, 3, 0, 0);
        drain();
        // R10: zero beat count
        issue("R10 zero beats", 26'h0000C0, 0, 2, 1'b1, 0, 2, 1);
        drain();
        // R3: width code 3 acts as 32-bit
        issue("R3 width code 3", 26'h000123, 3, 3, 1'b1, 1, 2, 1);
        drain();
        // R9: back-to-back request accepted in the done cycle
        issue("R9 first of pair", 26'h001000, 3, 2, 1'b1, 2, 3, 2);
        issue("R9 second of pair", 26'h002008, 2, 1, 1'b0, 0, 2, 1);
        drain();
        // R2: poke while busy and reprogram config mid-burst
        issue("R2 ignore while busy", 26'h003010, 6, 1, 1'b1, 1, 4, 2);
        req_valid     = 1'b1;
        req_addr      = 26'h3FFFFF;
        req_beats     = 8'd9;
        cfg_page_en   = 1'b0;
        cfg_first_len = 6'd9;
        cfg_next_len  = 6'd7;
        cfg_page_size = 2'd3;
        step();
        req_valid = 1'b0;
        step();
        drain();
        // R4 R6: long 16-bit burst over 32-byte pages
        issue("R4 R6 long burst", 26'h00401C, 20, 1, 1'b1, 3, 3, 1);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog R9 [%s] actual=hung expected=finished", cur_test);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule